// File: doc/BRIEF.md
# Fractional Baud Rate Divider

This block turns a free-running system clock into a periodic one-cycle enable, `tick`. The division ratio is an integer `n` plus a fraction `k/8`, with `k` from 0 to 7. The same enable can set the bit rate of a serial transmitter and receiver, or pace bytes out of a parallel port under timer control.

Every period between ticks is either `n` or `n+1` clock cycles long. A three-bit phase register adds `k` at every tick, and a carry out of it lengthens the next period by one cycle. The longer periods are therefore spread out rather than bunched together, and the long-run average period equals `n + k/8`.

A new ratio is presented on `div_int`/`div_frac` and captured with `load`. It never cuts a period short: it takes over at the next tick boundary.

Top module: `frac_baud_div`

## Requirements
- R1: `tick` is high for exactly one clock cycle at a time and is never high in two consecutive cycles.
- R2: While `rst` is high, `tick` is low and the divisor follows the `div_int`/`div_frac` inputs. The first `tick` comes in the n-th cycle after the last cycle with `rst` high.
- R3: The distance between two consecutive ticks is always `n` or `n+1` cycles of the divisor in force.
- R4: After the first period, each tick adds `k` to a 3-bit phase that starts at 0 after reset. The period that follows is `n+1` when that addition carries out of 3 bits, and `n` otherwise. As a result, exactly `k` of any 8 consecutive such periods are stretched.
- R5: A divisor presented with `load` high is captured. It governs every period that starts after the next tick. The period in progress keeps the old length. A `load` in the tick cycle itself applies to the very next period.
- R6: `div_int` is decoded as follows: the value 1 gives n = 2, the value 0 gives n = 16384, and any other value is n itself.
- R7: With `k` = 0, every period is exactly `n` cycles.
- R8: Changes on `div_int`/`div_frac` without `load` leave the tick spacing unchanged.
- R9: If `load` is pulsed several times before a tick boundary, only the last captured divisor takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_int | input | 14 | Integer part of the divisor (0 means 16384) |
| div_frac | input | 3 | Fractional part in eighths |
| load | input | 1 | Capture strobe for the divisor inputs |
| tick | output | 1 | One-cycle enable pulse |

## Verification
`tick` is decoded combinationally from the period counter, so a tick is visible in the same cycle the counter reaches its end value. The first tick comes `n` cycles after the last reset cycle, and each later tick comes `n` or `n+1` cycles after the one before. A captured load changes nothing until the tick that closes the period in progress.

The bench computes each expected period length ahead of time from the phase rule and queues it. A monitor samples on the falling clock edge, measures the cycle distance between ticks, and compares that distance with the head of the queue. Loads are driven one cycle after a tick, or deliberately inside the predicted tick cycle, so that the period expected to carry the old ratio is known exactly.

// File: rtl/fbd_pkg.sv
package fbd_pkg;
    localparam int INT_W  = 14;
    localparam int FRAC_W = 3;
    localparam int N_W    = INT_W + 1;
    localparam int N_MIN  = 2;
    localparam int N_MAX  = 1 << INT_W;

    typedef struct packed {
        logic [N_W-1:0]    n;
        logic [FRAC_W-1:0] k;
    } div_cfg_t;

    function automatic div_cfg_t decode_cfg(logic [INT_W-1:0] f, logic [FRAC_W-1:0] k);
        div_cfg_t c;
        if (f == '0)
            c.n = N_W'(N_MAX);
        else if (N_W'(f) < N_W'(N_MIN))
            c.n = N_W'(N_MIN);
        else
            c.n = N_W'(f);
        c.k = k;
        return c;
    endfunction
endpackage

// File: rtl/fbd_cfg_stage.sv
module fbd_cfg_stage
    import fbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              tick,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output div_cfg_t          cfg_act,
    output div_cfg_t          cfg_next
);
    div_cfg_t in_cfg, pend;
    logic     pend_v;

    assign in_cfg = decode_cfg(div_int, div_frac);

    always_comb begin
        if (load)
            cfg_next = in_cfg;
        else if (pend_v)
            cfg_next = pend;
        else
            cfg_next = cfg_act;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_act <= in_cfg;
            pend    <= in_cfg;
            pend_v  <= 1'b0;
        end else if (tick) begin
            cfg_act <= cfg_next;
            pend_v  <= 1'b0;
        end else if (load) begin
            pend    <= in_cfg;
            pend_v  <= 1'b1;
        end
    end
endmodule

// File: rtl/fbd_phase_acc.sv
module fbd_phase_acc
    import fbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [FRAC_W-1:0] k_next,
    output logic              stretch
);
    logic [FRAC_W-1:0] phase;
    logic [FRAC_W:0]   sum;

    assign sum = {1'b0, phase} + {1'b0, k_next};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= '0;
            stretch <= 1'b0;
        end else if (tick) begin
            phase   <= sum[FRAC_W-1:0];
            stretch <= sum[FRAC_W];
        end
    end
endmodule

// File: rtl/fbd_period_cnt.sv
module fbd_period_cnt
    import fbd_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [N_W-1:0] n_act,
    input  logic           stretch,
    output logic           tick
);
    logic [N_W-1:0] cnt;
    logic [N_W-1:0] last;

    assign last = n_act + N_W'(stretch) - N_W'(1);
    assign tick = !rst && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || tick)
            cnt <= '0;
        else
            cnt <= cnt + N_W'(1);
    end
endmodule

// File: rtl/frac_baud_div.sv
module frac_baud_div
    import fbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    input  logic              load,
    output logic              tick
);
    div_cfg_t       cfg_act, cfg_next;
    logic           stretch;
    logic [N_W-1:0] act_n;

    assign act_n = cfg_act.n;

    fbd_cfg_stage u_cfg (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .tick     (tick),
        .div_int  (div_int),
        .div_frac (div_frac),
        .cfg_act  (cfg_act),
        .cfg_next (cfg_next)
    );

    fbd_phase_acc u_acc (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .k_next  (cfg_next.k),
        .stretch (stretch)
    );

    fbd_period_cnt u_cnt (
        .clk     (clk),
        .rst     (rst),
        .n_act   (act_n),
        .stretch (stretch),
        .tick    (tick)
    );
endmodule

// File: rtl/fbd_checker.sv
module fbd_checker
    import fbd_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           tick,
    input logic [N_W-1:0] act_n
);
    logic [N_W:0] gap;

    always_ff @(posedge clk) begin
        if (rst || tick)
            gap <= (N_W+1)'(1);
        else if (gap != '1)
            gap <= gap + (N_W+1)'(1);
    end

    a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    a_r2_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !tick);

    // R3: spacing is n or n+1 of the ratio that governed the ending period
    a_r3_gap_range: assert property (@(posedge clk) disable iff (rst)
        tick |-> (gap == {1'b0, act_n} || gap == {1'b0, act_n} + (N_W+1)'(1)));

    a_r5_hold_mid_period: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(act_n));

    a_r6_legal_n: assert property (@(posedge clk) disable iff (rst)
        (act_n >= N_W'(N_MIN)) && (act_n <= N_W'(N_MAX)));
endmodule

bind frac_baud_div fbd_checker u_chk (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .act_n (act_n)
);

// File: tb/sim_frac_baud_div.sv
module sim_frac_baud_div;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [13:0] div_int = 14'd0;
    logic [2:0]  div_frac = 3'd0;
    logic        tick;

    always #4 clk = ~clk;

    frac_baud_div u0 (
        .clk(clk), .rst(rst), .div_int(div_int),
        .div_frac(div_frac), .load(load), .tick(tick)
    );

    typedef struct {
        int    p;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   last = 0;
    logic prev_tick = 1'b0;
    bit   done = 1'b0;
    int   m_n, m_k, m_acc;
    bit   m_first;

    task automatic chk(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    function automatic int dec(int f);
        if (f == 0) return 16384;
        if (f < 2) return 2;
        return f;
    endfunction

    // expected length of the next period from the phase rule (R4)
    function automatic int next_period();
        int s;
        if (m_first) begin
            m_first = 1'b0;
            return m_n;
        end
        s = m_acc + m_k;
        m_acc = s % 8;
        return m_n + ((s >= 8) ? 1 : 0);
    endfunction

    task automatic push(int cnt, string tag);
        repeat (cnt) begin
            exp_t e;
            e.p = next_period();
            e.tag = tag;
            q.push_back(e);
        end
    endtask

    // monitor: measures tick spacing at the falling edge
    always @(negedge clk) begin : mon
        exp_t e;
        cyc++;
        if (rst) begin
            chk(tick === 1'b0, "R2 tick low in reset", int'(tick), 0);
            last = cyc;
        end else if (tick === 1'b1) begin
            chk(prev_tick === 1'b0, "R1 single-cycle tick", int'(prev_tick), 0);
            if (q.size() == 0) begin
                chk(1'b0, "R3 unexpected tick", cyc - last, 0);
            end else begin
                e = q.pop_front();
                chk(cyc - last == e.p, e.tag, cyc - last, e.p);
            end
            last = cyc;
        end
        prev_tick = tick;
    end

    task automatic do_reset(int nf, int k, int cnt, string tag);
        wait (q.size() == 0);
        @(posedge clk); #1;
        rst = 1'b1;
        div_int = 14'(nf);
        div_frac = 3'(k);
        m_n = dec(nf); m_k = k; m_acc = 0; m_first = 1'b1;
        push(1, "R2 first tick after reset");
        push(cnt, tag);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    // off > 0: load high in cycle T+off after tick T; off = 0: inside the next tick cycle
    task automatic load_at(int off, int nf, int k, int cnt, string tag);
        int w;
        wait (q.size() == 0);
        push(1, "R5 old period kept");
        w = (off == 0) ? q[q.size()-1].p : off;
        repeat (w) @(posedge clk);
        #1 load = 1'b1; div_int = 14'(nf); div_frac = 3'(k);
        @(posedge clk); #1 load = 1'b0;
        m_n = dec(nf); m_k = k;
        push(cnt, tag);
    endtask

    initial begin
        do_reset(10, 0, 9, "R7 integer-only period");
        load_at(1, 7, 3, 17, "R3/R4 fraction 3/8 pattern");
        load_at(0, 5, 5, 16, "R5 load in tick cycle, fraction 5/8");
        load_at(1, 1, 2, 9, "R6 field 1 clamps to 2");
        load_at(1, 4, 1, 8, "R4 fraction 1/8");
        // R8: inputs move without load
        wait (q.size() == 0);
        @(posedge clk); #1;
        div_int = 14'd9; div_frac = 3'd6;
        push(8, "R8 inputs ignored without load");
        // R9: two loads before one boundary
        wait (q.size() == 0);
        push(1, "R5 old period kept");
        @(posedge clk); #1 load = 1'b1; div_int = 14'd12; div_frac = 3'd1;
        @(posedge clk); #1 div_int = 14'd3; div_frac = 3'd6;
        @(posedge clk); #1 load = 1'b0;
        m_n = 3; m_k = 6;
        push(10, "R9 last load wins");
        do_reset(3, 4, 8, "R2/R4 ratio taken at reset");
        load_at(1, 0, 7, 3, "R6 field 0 encodes 16384");
        wait (q.size() == 0);
        repeat (5) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired, %0d periods pending", q.size());
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule